// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two operands of `WIDTH` bits over many clock cycles and gives the full product of twice that width. It has one adder of `WIDTH + 1` bits, one multiplicand register and one product register of `2*WIDTH` bits. A start pulse loads the multiplier into the low half of the product register and clears the high half. Each later cycle checks the lowest bit of the product register. If that bit is set, the cycle adds the multiplicand into the high half. The cycle then shifts the whole register right by one place. The right shift uses up the multiplier bits from the least significant end, so no separate multiplier register is needed.

A mode input picks between unsigned and two's complement operands. The mode is sampled together with the operands when a start is accepted. In signed mode the bit shifted into the top of the register is the true sign of the partial sum. In the final step a set multiplier bit makes the adder subtract the multiplicand instead of adding it, because the top bit of a two's complement multiplier carries negative weight. In unsigned mode the carry out of the adder is shifted in. The result is not checked for overflow. All `2*WIDTH` bits are always presented.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done_o` is 0 and `product_o` is all zeros.
- R2: With `signed_i` = 0 at start, `product_o` equals the unsigned product of `mcand_i` and `mplier_i`, in full `2*WIDTH` bits.
- R3: With `signed_i` = 1 at start, both operands are read as two's complement, and `product_o` equals their signed product as a `2*WIDTH`-bit two's complement value.
- R4: A start that is sampled at clock edge k makes `done_o` high from edge k+WIDTH to edge k+WIDTH+1 only. That is, `done_o` is a single-cycle pulse after exactly `WIDTH` add/shift steps.
- R5: After a run completes, `product_o` keeps its value until the clock edge at which the next start is accepted.
- R6: A start pulse that arrives while a run is in progress is ignored. It changes neither the result nor the time at which `done_o` rises.
- R7: Extreme operands give exact results: all ones times all ones in unsigned mode, and the most negative value times itself or times -1 in signed mode.
- R8: `mcand_i`, `mplier_i` and `signed_i` are sampled only when a start is accepted. Changes to them during a run have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; accepted only when idle |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Full product |

## Verification
On every cycle, the assertions check four things: that reset clears the outputs, that `done_o` is a single-cycle pulse that follows a run, that a run cannot end early even if a start arrives, and that the product holds still while the block is idle and no start is present. Whether the arithmetic is correct can only be shown by the bench. The bench sweeps every operand pair and both modes at a width of four, and covers the extreme values at full width. The bench also injects stray starts and changes the operands during a run, so that the ignore and sampling rules are checked at the ports.

// File: rtl/shift_add_mul_pkg.sv
package shift_add_mul_pkg;
   typedef enum logic {
      MUL_IDLE = 1'b0,
      MUL_RUN  = 1'b1
   } mul_state_t;
endpackage

// File: rtl/mul_seq.sv
module mul_seq
   import shift_add_mul_pkg::*;
#(
   parameter int STEPS = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic last_o,
   output logic done_o
);
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

   mul_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign load_o = (state_q == MUL_IDLE) && start_i;
   assign step_o = (state_q == MUL_RUN);
   assign last_o = step_o && (cnt_q == LAST_CNT);
   assign done_o = done_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= MUL_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last_o;
         if (load_o) begin
            state_q <= MUL_RUN;
            cnt_q   <= '0;
         end else if (last_o) begin
            state_q <= MUL_IDLE;
         end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
   parameter int WIDTH = 32
) (
   input  logic [2*WIDTH-1:0] prod_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic               sgn_i,
   input  logic               last_i,
   output logic [2*WIDTH-1:0] prod_o
);
   localparam int EXT_W = WIDTH + 1;

   logic [WIDTH-1:0] upper;
   logic [EXT_W-1:0] upper_ext;
   logic [EXT_W-1:0] mcand_ext;
   logic [EXT_W-1:0] addend;
   logic [EXT_W-1:0] sum;
   logic             subtract;

   assign upper     = prod_i[2*WIDTH-1:WIDTH];
   assign upper_ext = {sgn_i & upper[WIDTH-1], upper};
   assign mcand_ext = {sgn_i & mcand_i[WIDTH-1], mcand_i};
   assign addend    = prod_i[0] ? mcand_ext : '0;
   assign subtract  = sgn_i & last_i & prod_i[0];
   assign sum       = subtract ? (upper_ext - addend) : (upper_ext + addend);
   assign prod_o    = {sum, prod_i[WIDTH-1:1]};
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
   import shift_add_mul_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter bit SIGNED_EN = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [WIDTH-1:0]   mcand_i,
   input  logic [WIDTH-1:0]   mplier_i,
   input  logic               signed_i,
   output logic               done_o,
   output logic [2*WIDTH-1:0] product_o
);
   localparam int PROD_W = 2 * WIDTH;

   if (WIDTH < 2) begin : g_bad_width
      $error("shift_add_mul: WIDTH must be at least 2");
   end

   logic              load;
   logic              busy;
   logic              last;
   logic [PROD_W-1:0] prod_q;
   logic [PROD_W-1:0] prod_d;
   logic [WIDTH-1:0]  mcand_q;
   logic              sgn_q;

   mul_seq #(.STEPS(WIDTH)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(start_i),
      .load_o (load),
      .step_o (busy),
      .last_o (last),
      .done_o (done_o)
   );

   mul_step #(.WIDTH(WIDTH)) u_step (
      .prod_i (prod_q),
      .mcand_i(mcand_q),
      .sgn_i  (sgn_q),
      .last_i (last),
      .prod_o (prod_d)
   );

   if (SIGNED_EN) begin : g_mode
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)   sgn_q <= 1'b0;
         else if (load) sgn_q <= signed_i;
      end
   end else begin : g_unsigned_only
      assign sgn_q = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prod_q  <= '0;
         mcand_q <= '0;
      end else if (load) begin
         prod_q  <= {{WIDTH{1'b0}}, mplier_i};
         mcand_q <= mcand_i;
      end else if (busy) begin
         prod_q <= prod_d;
      end
   end

   assign product_o = prod_q;
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
   parameter int WIDTH = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               start_i,
   input logic               busy_i,
   input logic               last_i,
   input logic               done_i,
   input logic [2*WIDTH-1:0] product_i
);
   assert_reset_clear_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (!done_i && product_i == '0));

   assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   assert_done_after_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> $past(busy_i));

   assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_i && !start_i) |=> $stable(product_i));

   assert_run_continues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !last_i) |=> busy_i);
endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .start_i  (start_i),
   .busy_i   (busy),
   .last_i   (last),
   .done_i   (done_o),
   .product_i(product_o)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   checks = 0;
   int   fails = 0;

   logic            s_start = 1'b0, s_sgn = 1'b0;
   logic [SW-1:0]   s_a = '0, s_b = '0;
   logic            s_done;
   logic [2*SW-1:0] s_prod;

   logic            w_start = 1'b0, w_sgn = 1'b0;
   logic [WW-1:0]   w_a = '0, w_b = '0;
   logic            w_done;
   logic [2*WW-1:0] w_prod;

   always #(CLK_PERIOD/2) clk = ~clk;

   shift_add_mul #(.WIDTH(SW)) u_shift_add_mul (
      .clk_i(clk), .rst_ni(rst_n), .start_i(s_start), .mcand_i(s_a),
      .mplier_i(s_b), .signed_i(s_sgn), .done_o(s_done), .product_o(s_prod));

   shift_add_mul #(.WIDTH(WW)) u_shift_add_mul_wide (
      .clk_i(clk), .rst_ni(rst_n), .start_i(w_start), .mcand_i(w_a),
      .mplier_i(w_b), .signed_i(w_sgn), .done_o(w_done), .product_o(w_prod));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [2*SW-1:0] s_exp(input logic [SW-1:0] a,
         input logic [SW-1:0] b, input logic sg);
      logic [2*SW-1:0] ea, eb;
      ea = sg ? {{SW{a[SW-1]}}, a} : {{SW{1'b0}}, a};
      eb = sg ? {{SW{b[SW-1]}}, b} : {{SW{1'b0}}, b};
      return ea * eb;
   endfunction

   function automatic logic [2*WW-1:0] w_exp(input logic [WW-1:0] a,
         input logic [WW-1:0] b, input logic sg);
      logic [2*WW-1:0] ea, eb;
      ea = sg ? {{WW{a[WW-1]}}, a} : {{WW{1'b0}}, a};
      eb = sg ? {{WW{b[WW-1]}}, b} : {{WW{1'b0}}, b};
      return ea * eb;
   endfunction

   // Small instance run. stray: pulse start again at step 2 (R6);
   // scramble: change operands and mode during the run (R8).
   task automatic s_run(input logic [SW-1:0] a, input logic [SW-1:0] b,
                        input logic sg, input bit stray, input bit scramble,
                        input string req);
      int n;
      logic [2*SW-1:0] e;
      e = s_exp(a, b, sg);
      @(negedge clk);
      s_a = a; s_b = b; s_sgn = sg; s_start = 1'b1;
      @(negedge clk);
      s_start = 1'b0;
      if (scramble) begin s_a = ~a; s_b = b ^ 4'h5; s_sgn = ~sg; end
      n = 0;
      while (!s_done && n < SW + 4) begin
         @(negedge clk);
         n++;
         if (stray && n == 2) s_start = 1'b1;
         else s_start = 1'b0;
      end
      s_start = 1'b0;
      chk(n == SW, "R4 latency", 64'(n), 64'(SW));
      chk(s_prod == e, req, 64'(s_prod), 64'(e));
      @(negedge clk);
      chk(!s_done, "R4 single pulse", 64'(s_done), 64'd0);
   endtask

   task automatic w_run(input logic [WW-1:0] a, input logic [WW-1:0] b,
                        input logic sg, input string req);
      int n;
      logic [2*WW-1:0] e;
      e = w_exp(a, b, sg);
      @(negedge clk);
      w_a = a; w_b = b; w_sgn = sg; w_start = 1'b1;
      @(negedge clk);
      w_start = 1'b0;
      n = 0;
      while (!w_done && n < WW + 4) begin
         @(negedge clk);
         n++;
      end
      chk(n == WW, "R4 latency wide", 64'(n), 64'(WW));
      chk(w_prod == e, req, w_prod, e);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      logic [2*SW-1:0] held;
      repeat (3) @(negedge clk);
      // R1: outputs clear under reset and right after release
      chk(!s_done && s_prod == '0, "R1 reset", 64'(s_prod), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!w_done && w_prod == '0, "R1 after reset", w_prod, 64'd0);

      // R2 and R3: exhaustive sweep at width 4
      for (int sg = 0; sg < 2; sg++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               s_run(4'(a), 4'(b), 1'(sg), 1'b0, 1'b0, sg ? "R3 signed" : "R2 unsigned");

      // R6: stray start during a run
      s_run(4'd13, 4'd11, 1'b0, 1'b1, 1'b0, "R6 stray start unsigned");
      s_run(4'd9, 4'd6, 1'b1, 1'b1, 1'b0, "R6 stray start signed");
      // R8: inputs changed during a run
      s_run(4'd7, 4'd12, 1'b1, 1'b0, 1'b1, "R8 inputs sampled at start");
      s_run(4'd15, 4'd3, 1'b0, 1'b0, 1'b1, "R8 mode sampled at start");

      // R5: hold while idle with changing inputs
      held = s_prod;
      for (int i = 0; i < 6; i++) begin
         s_a = 4'(i * 3); s_b = 4'(i + 5); s_sgn = 1'(i);
         @(negedge clk);
      end
      chk(s_prod == held, "R5 product held", 64'(s_prod), 64'(held));

      // R7 and full-width cases
      w_run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R7 unsigned max*max");
      w_run(32'h8000_0000, 32'h8000_0000, 1'b1, "R7 signed min*min");
      w_run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7 signed min*-1");
      w_run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R7 signed max*min");
      w_run(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R2 unsigned wide");
      w_run(32'hFFFF_FFFF, 32'h0000_0001, 1'b1, "R3 signed -1*1 wide");
      w_run(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, "R3 signed wide");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule